// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR-style flash and decides when an embedded program or erase operation inside the device has finished. Whatever logic launched the operation pulses `start`. The poller then reads status bytes through a request/acknowledge read port and watches two bits. Bit 6 flips on every read while the device is busy. Bit 5 rises when the device has run past its own time limit.

Reads are taken in pairs. When bit 6 has the same value in both reads, the device is idle and the poller pulses `done`. When bit 6 differs and bit 5 is clear, another pair follows. When bit 6 differs and bit 5 is set, the poller takes one more confirming pair, because toggling can stop at the same moment bit 5 rises. If that confirming pair still toggles, the operation has failed. A typical cause is programming a 1 over a cell that already holds 0, which only an erase can undo. In that case the poller writes the reset command so that the device returns to array reads, and then pulses `fail`.

A software-set ceiling on the number of ordinary pairs keeps a device that never settles from holding the poller forever.

Top module: `flash_toggle_poller`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `fail`, `rd_req` and `wr_req` are all low until a start is accepted.
- R2: After an accepted `start`, reads are issued in pairs. `rd_req` stays high until `rd_ack`, and each acknowledged cycle consumes one byte from `rd_data`. When bit 6 is equal in both bytes of a pair, `done` pulses in the cycle after the acknowledge of the pair's second read, and no further access follows.
- R3: When bit 6 differs within a pair and bit 5 of that pair's second byte is 0, a new pair of reads starts, provided the poll ceiling (R7) has not been reached.
- R4: When bit 6 differs within a pair and bit 5 of the second byte is 1, exactly one confirming pair is read. If bit 6 is equal within the confirming pair, `done` pulses in the cycle after its second acknowledge.
- R5: When bit 6 still differs within the confirming pair, exactly one write of the byte 0xF0 is requested. `wr_req` and `wr_data` are held until `wr_ack`, and `fail` pulses in the cycle after that acknowledge.
- R6: `busy` rises in the cycle after an accepted `start` and stays high until the cycle in which `done` or `fail` pulses, where it is low. `done` and `fail` last one cycle each and are never high together.
- R7: When the N-th ordinary pair (N = `max_polls`, with 0 treated as 1) toggles with bit 5 clear, the poller issues the reset write of R5 and then pulses `fail` instead of starting another pair.
- R8: A `start` pulse while `busy` is high has no effect: the read count, the outcome and the number of pulses stay those of the running operation.
- R9: `rd_req` and `wr_req` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling; ignored while busy |
| max_polls | input | CNT_W | Ceiling on ordinary read pairs (0 acts as 1) |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid in this cycle |
| rd_data | input | 8 | Status byte from the device |
| wr_req | output | 1 | Command write request |
| wr_ack | input | 1 | Write acknowledge |
| wr_data | output | 8 | Command byte (0xF0 during the reset write) |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: operation failed, reset already written |

## Verification
A corrupted poll state shows at the ports in one of three ways: the number of reads differs from the count implied by the status script, a write appears when none is due or is missing when one is due, or the outcome pulse is the wrong one. Each of these can be seen within the acknowledge cycle of the read where the decision diverges, or in the cycle after it. Timing faults, such as a pulse that is late or a request dropped before its acknowledge, show within one cycle of the acknowledge involved. A broken pair counter shows as one pair too many or too few before `fail`.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
    localparam int DATA_W    = 8;
    localparam int TGL_BIT   = 6;
    localparam int ERR_BIT   = 5;
    localparam logic [DATA_W-1:0] RESET_CMD = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RC_A,
        ST_RC_B,
        ST_RST
    } ftp_state_e;

    typedef struct packed {
        ftp_state_e st;
        logic       held_tgl;
        logic       busy;
        logic       done;
        logic       fail;
    } ftp_regs_t;
endpackage

// File: rtl/ftp_bit_compare.sv
module ftp_bit_compare #(
    parameter int DATA_W  = 8,
    parameter int TGL_BIT = 6,
    parameter int ERR_BIT = 5
) (
    input  logic              held_tgl,
    input  logic [DATA_W-1:0] data,
    output logic              toggling,
    output logic              err_flag
);
    // toggle judged against the bit captured on the first read of a pair
    always_comb begin
        toggling = data[TGL_BIT] ^ held_tgl;
        err_flag = data[ERR_BIT];
    end
endmodule

// File: rtl/ftp_poll_limit.sv
module ftp_poll_limit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] eff_limit;

    always_comb begin
        eff_limit = (limit == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : limit;
        cnt_d     = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (step)
            cnt_d = cnt_q + 1'b1;
        last = ({1'b0, cnt_q} + EXT_W'(1)) >= {1'b0, eff_limit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R7: a step is never taken on the pair that reaches the ceiling
    a_r7_no_step_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last);
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
    import ftp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  max_polls,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    input  logic              wr_ack,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    ftp_regs_t r_d, r_q;
    logic      toggling, err_flag;
    logic      cnt_clear, cnt_step, cnt_last;

    ftp_bit_compare #(
        .DATA_W  (DATA_W),
        .TGL_BIT (TGL_BIT),
        .ERR_BIT (ERR_BIT)
    ) cmp_i (
        .held_tgl (r_q.held_tgl),
        .data     (rd_data),
        .toggling (toggling),
        .err_flag (err_flag)
    );

    ftp_poll_limit #(
        .CNT_W (CNT_W)
    ) lim_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .step  (cnt_step),
        .limit (max_polls),
        .last  (cnt_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fail  = 1'b0;
        cnt_clear = 1'b0;
        cnt_step  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_RD_A;
                    r_d.busy  = 1'b1;
                    cnt_clear = 1'b1;
                end
            end
            ST_RD_A: begin
                if (rd_ack) begin
                    r_d.held_tgl = rd_data[TGL_BIT];
                    r_d.st       = ST_RD_B;
                end
            end
            ST_RD_B: begin
                if (rd_ack) begin
                    if (!toggling) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                    end else if (err_flag) begin
                        r_d.st = ST_RC_A;
                    end else if (cnt_last) begin
                        r_d.st = ST_RST;
                    end else begin
                        r_d.st   = ST_RD_A;
                        cnt_step = 1'b1;
                    end
                end
            end
            ST_RC_A: begin
                if (rd_ack) begin
                    r_d.held_tgl = rd_data[TGL_BIT];
                    r_d.st       = ST_RC_B;
                end
            end
            ST_RC_B: begin
                if (rd_ack) begin
                    if (!toggling) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_RST;
                    end
                end
            end
            ST_RST: begin
                if (wr_ack) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.fail = 1'b1;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.held_tgl <= 1'b0;
            r_q.busy     <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.fail     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_req  = (r_q.st == ST_RD_A) || (r_q.st == ST_RD_B) ||
                  (r_q.st == ST_RC_A) || (r_q.st == ST_RC_B);
        wr_req  = (r_q.st == ST_RST);
        wr_data = wr_req ? RESET_CMD : '0;
        busy    = r_q.busy;
        done    = r_q.done;
        fail    = r_q.fail;
    end

    // R6: outcome pulses exclusive, busy low while they show
    a_r6_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    a_r6_busy_low_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !busy);
    a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2: read request held until acknowledged
    a_r2_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);
    a_r2_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_req && rd_ack));
    // R5: reset write held and fail follows its acknowledge
    a_r5_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && wr_data == RESET_CMD));
    a_r5_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(wr_req && wr_ack));
    // R9: bus quiet when idle, never both requests
    a_r9_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_req));
endmodule

// File: tb/flash_toggle_poller_tb_top.sv
module flash_toggle_poller_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] max_polls = '0;
    logic             rd_req, rd_ack = 1'b0;
    logic [7:0]       rd_data = '0;
    logic             wr_req, wr_ack = 1'b0;
    logic [7:0]       wr_data;
    logic             busy, done, fail;

    flash_toggle_poller #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .max_polls(max_polls),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
        .busy(busy), .done(done), .fail(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] script [256];

    // device model and monitor state
    int cyc = 0, reads = 0, writes = 0, wr_bad = 0;
    int n_done = 0, n_fail = 0, done_cyc = 0, fail_cyc = 0;
    int rd_ack_cyc = 0, wr_ack_cyc = 0, rd_wait = 0, wr_wait = 0;
    int busy_gap = 0;
    bit op_live = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (done) begin n_done++; done_cyc = cyc; op_live = 0; end
        if (fail) begin n_fail++; fail_cyc = cyc; op_live = 0; end
        if (op_live && !busy) busy_gap++;
        if (rd_ack) rd_ack = 1'b0;
        else if (rd_req) begin
            if (rd_wait > 0) rd_wait--;
            else begin
                rd_ack = 1'b1;
                rd_data = script[reads[7:0]];
                reads++;
                rd_ack_cyc = cyc;
                rd_wait = int'($urandom_range(0, 2));
            end
        end
        if (wr_ack) wr_ack = 1'b0;
        else if (wr_req) begin
            if (wr_wait > 0) wr_wait--;
            else begin
                wr_ack = 1'b1;
                writes++;
                if (wr_data != 8'hF0) wr_bad++;
                wr_ack_cyc = cyc;
                wr_wait = int'($urandom_range(0, 2));
            end
        end
    end

    task automatic build(int stop_at, int err_at, bit phase);
        for (int i = 0; i < 256; i++) begin
            int k;
            logic [7:0] b;
            k = (i < stop_at) ? i : stop_at;
            b = 8'($urandom);
            b[6] = k[0] ^ phase;
            b[5] = (i >= err_at);
            script[i] = b;
        end
    endtask

    // expected outcome from the polling rules; returns reads, sets is_fail
    function automatic int predict(int maxp, output bit is_fail);
        int i = 0, pairs = 0, eff;
        eff = (maxp == 0) ? 1 : maxp;
        is_fail = 0;
        forever begin
            bit a, b;
            a = script[i][6]; b = script[i+1][6];
            i += 2;
            if (a == b) return i;
            if (script[i-1][5]) begin
                a = script[i][6]; b = script[i+1][6];
                i += 2;
                is_fail = (a != b);
                return i;
            end
            pairs++;
            if (pairs >= eff) begin is_fail = 1; return i; end
        end
    endfunction

    task automatic run_op(int stop_at, int err_at, int maxp, bit dbl, string tag);
        bit exp_fail;
        int exp_reads;
        build(stop_at, err_at, 1'($urandom));
        exp_reads = predict(maxp, exp_fail);
        @(negedge clk);
        reads = 0; writes = 0; wr_bad = 0; n_done = 0; n_fail = 0; busy_gap = 0;
        max_polls = CNT_W'(maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_live = 1;
        chk(busy === 1'b1, "R6", {tag, " busy after start"}, int'(busy), 1);
        if (dbl) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 3000 && (n_done + n_fail) == 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk((n_done + n_fail) == 1, "R6", {tag, " single outcome pulse"}, n_done + n_fail, 1);
        chk(busy_gap == 0, "R6", {tag, " busy held"}, busy_gap, 0);
        chk(reads == exp_reads, dbl ? "R8" : "R2", {tag, " read count"}, reads, exp_reads);
        if (exp_fail) begin
            chk(n_fail == 1, "R5", {tag, " fail outcome"}, n_fail, 1);
            chk(writes == 1 && wr_bad == 0, "R5", {tag, " one 0xF0 write"}, writes, 1);
            chk(fail_cyc == wr_ack_cyc + 1, "R5", {tag, " fail timing"}, fail_cyc, wr_ack_cyc + 1);
        end else begin
            chk(n_done == 1, "R2", {tag, " done outcome"}, n_done, 1);
            chk(writes == 0, "R9", {tag, " no write"}, writes, 0);
            chk(done_cyc == rd_ack_cyc + 1, "R2", {tag, " done timing"}, done_cyc, rd_ack_cyc + 1);
        end
        chk(!rd_req && !wr_req && !busy, "R9", {tag, " bus quiet after"}, int'(rd_req | wr_req | busy), 0);
    endtask

    initial begin
        void'($urandom(32'd20231));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !rd_req && !wr_req, "R1", "outputs in reset",
            int'({busy, done, fail, rd_req, wr_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !fail && !rd_req && !wr_req, "R1", "outputs after reset",
            int'({busy, done, fail, rd_req, wr_req}), 0);
        run_op(0, 999, 5, 0, "R2 immediate idle");
        run_op(7, 999, 10, 0, "R3 several pairs");
        run_op(4, 3, 10, 0, "R4 recheck settles");
        run_op(200, 5, 10, 0, "R5 recheck toggles");
        run_op(200, 999, 4, 0, "R7 ceiling four");
        run_op(200, 999, 0, 0, "R7 ceiling zero");
        run_op(20, 999, 30, 1, "R8 start while busy");
        for (int n = 0; n < 40; n++)
            run_op(int'($urandom_range(0, 30)), int'($urandom_range(0, 40)),
                   int'($urandom_range(0, 12)), 0, "random");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule